// File: doc/BRIEF.md
# External Sync Relock for a 625-Line Timing Counter

This block keeps the horizontal and vertical counters of a 625-line, 944-clock-per-line timing generator in step with two external active-low reset strobes: a line strobe and a frame strobe. It drives the line sync (HD), the vertical sync (VD) and a field flag. The vertical position is kept in half-lines, so a field boundary can land either on the HD fall or in the middle of a line. This is what lets interlaced frames alternate between an even field and an odd field.

Each falling edge of the frame strobe is classified as even or odd from where it lands in the current line, and the VD fall is then moved to a boundary of that type. Two relock styles exist. In the continuous style, the counters keep free-running and the frame relock is applied only after a fixed delay measured in half-lines. Small drift on the line strobe is absorbed. In the forcing style, the frame relock is applied at the next matching boundary. If the combined line-and-frame variant is chosen, every line strobe restarts the line.

Top module: `ext_sync_relock`

## Requirements
- R1: During and just after reset, hd_n=0, vd_n=0 and field_even=1. The active modes are interlaced, continuous style and line-and-frame relock.
- R2: While free-running, hd_n falls every LINE_CLKS clocks and stays low for HD_WIDTH clocks.
- R3: While interlaced and free-running, vd_n falls every FRAME_LINES*LINE_CLKS/2 clocks. The falls alternate between the HD fall (field_even=1) and mid-line, LINE_CLKS/2 clocks after it (field_even=0).
- R4: Both strobes pass through a two-flop synchronizer. The first hri_n fall after reset always restarts the line: the line count is zero after the second rising edge that follows the edge first sampling hri_n low.
- R5: After the first line relock, and outside the forcing line-and-frame combination, an hri_n fall is ignored if the count the line would have reached lies within JITTER_CLKS clocks of zero in either direction. Otherwise the fall restarts the line as in R4.
- R6: In the continuous style, the half-line boundaries are counted after the frame strobe fall is registered. vd_n falls at the first boundary of the classified type that comes after at least V_DELAY_HALVES boundaries. The default of 619 gives 309.5 lines.
- R7: A vri_n fall is classified from p, the clocks since the HD fall, as held after the edge that follows the first edge sampling vri_n low. The fall is odd if p < ODD_LIMIT, even if p < EVEN_LIMIT, and odd otherwise. After an even fall, vd_n falls at an HD fall with field_even=1. After an odd fall, it falls mid-line with field_even=0.
- R8: A fall whose p is within GUARD_CLKS of ODD_LIMIT, of EVEN_LIMIT, or of the line wrap reuses the parity of the previous classified fall.
- R9: In the forcing style with frame-only relock, vd_n falls at the first boundary of the classified type after the fall is registered, with no delay.
- R10: In the forcing style with line-and-frame relock, every hri_n fall restarts the line, including falls inside the jitter window.
- R11: direct_sel, hv_sel and interlace_sel take effect only when the half-line count re-enters zero, which is the start of a frame.
- R12: When non-interlaced, vd_n falls once per frame, field_even stays 0, the continuous style behaves as the forcing style, and every vri_n fall moves the frame start to the next HD fall whatever its position in the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hri_n | input | 1 | External line reset strobe, acts on falling edge |
| vri_n | input | 1 | External frame reset strobe, acts on falling edge |
| direct_sel | input | 1 | 1 selects the forcing style, 0 the continuous style |
| hv_sel | input | 1 | 1 selects line-and-frame relock in the forcing style, 0 frame-only |
| interlace_sel | input | 1 | 1 selects interlaced, 0 non-interlaced |
| hd_n | output | 1 | Line sync, active low |
| vd_n | output | 1 | Vertical sync, active low |
| field_even | output | 1 | 1 for the even field, 0 for the odd field |

## Verification
The bench builds the block with 40-clock lines, 11-line frames, a 6-half-line continuous delay, a 2-clock jitter window and classification limits at 14 and 34 with a 1-clock guard. At these values, a whole frame lasts 440 clocks, so many frames fit in a short run. Every classification window and guard zone can then be hit on exact clocks, and the jitter window edges can be probed one clock inside and one clock outside. Mode changes are made just after a frame start, so the run shows that they wait for the next frame.

// File: rtl/ext_sync_relock.sv
module ext_sync_relock #(
  parameter int LINE_CLKS      = 944,
  parameter int FRAME_LINES    = 625,
  parameter int HD_WIDTH       = 73,
  parameter int VD_HALVES      = 5,
  parameter int V_DELAY_HALVES = 619,
  parameter int JITTER_CLKS    = 2,
  parameter int ODD_LIMIT      = 325,
  parameter int EVEN_LIMIT     = 794,
  parameter int GUARD_CLKS     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hri_n,
  input  logic vri_n,
  input  logic direct_sel,
  input  logic hv_sel,
  input  logic interlace_sel,
  output logic hd_n,
  output logic vd_n,
  output logic field_even
);

  localparam int HW     = $clog2(LINE_CLKS);
  localparam int HALVES = 2 * FRAME_LINES;
  localparam int VW     = $clog2(HALVES);
  localparam int DW     = $clog2(V_DELAY_HALVES + 2);

  localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] HALF_H = HW'(LINE_CLKS / 2);
  localparam logic [HW-1:0] HDW_H  = HW'(HD_WIDTH);
  localparam logic [HW-1:0] JIT_LO = HW'(JITTER_CLKS);
  localparam logic [HW-1:0] JIT_HI = HW'(LINE_CLKS - JITTER_CLKS);
  localparam logic [HW-1:0] G_LO   = HW'(GUARD_CLKS);
  localparam logic [HW-1:0] G_HI   = HW'(LINE_CLKS - GUARD_CLKS);
  localparam logic [HW-1:0] A_H    = HW'(ODD_LIMIT);
  localparam logic [HW-1:0] A_LO   = HW'(ODD_LIMIT - GUARD_CLKS);
  localparam logic [HW-1:0] A_HI   = HW'(ODD_LIMIT + GUARD_CLKS);
  localparam logic [HW-1:0] B_H    = HW'(EVEN_LIMIT);
  localparam logic [HW-1:0] B_LO   = HW'(EVEN_LIMIT - GUARD_CLKS);
  localparam logic [HW-1:0] B_HI   = HW'(EVEN_LIMIT + GUARD_CLKS);
  localparam logic [VW-1:0] V_LAST = VW'(HALVES - 1);
  localparam logic [VW-1:0] V_MID  = VW'(FRAME_LINES);
  localparam logic [VW-1:0] V_MEND = VW'(FRAME_LINES + VD_HALVES);
  localparam logic [VW-1:0] VDW_V  = VW'(VD_HALVES);
  localparam logic [DW-1:0] DELAY  = DW'(V_DELAY_HALVES);

  logic [2:0]    hri_q, vri_q;
  logic [HW-1:0] hcnt, h_nxt, hcnt_d;
  logic [VW-1:0] vhl, vhl_inc, vhl_step, vhl_d;
  logic [DW-1:0] pend_cnt, need;
  logic m_direct, m_hv, m_ilace, h_locked, fld, last_even, pend, pend_even;
  logic h_fall, v_fall, eff_direct, h_hard, in_jit, h_force;
  logic line_tick, mid_tick, pend_hit, enter0, enter_mid;
  logic prohib, raw_even, cls_even;

  assign h_fall     = hri_q[2] & ~hri_q[1];
  assign v_fall     = vri_q[2] & ~vri_q[1];
  assign eff_direct = m_direct | ~m_ilace;
  assign h_hard     = eff_direct & m_hv;

  assign h_nxt   = (hcnt == H_LAST) ? '0 : hcnt + 1'b1;
  assign in_jit  = (h_nxt <= JIT_LO) || (h_nxt >= JIT_HI);
  assign h_force = h_fall & (h_hard | ~h_locked | ~in_jit);
  assign hcnt_d  = h_force ? '0 : h_nxt;

  assign line_tick = (hcnt_d == '0) && (hcnt != '0);
  assign mid_tick  = (hcnt_d == HALF_H) && (hcnt != HALF_H);
  assign vhl_inc   = (vhl == V_LAST) ? '0 : vhl + 1'b1;
  assign vhl_step  = (mid_tick || (line_tick && vhl[0])) ? vhl_inc : vhl;

  assign need     = eff_direct ? '0 : DELAY;
  assign pend_hit = pend && (pend_even ? line_tick : mid_tick) && (pend_cnt >= need);
  assign vhl_d    = pend_hit ? (pend_even ? '0 : V_MID) : vhl_step;

  assign enter0    = (vhl_d == '0) && (vhl != '0);
  assign enter_mid = (vhl_d == V_MID) && (vhl != V_MID);

  assign prohib = (hcnt < G_LO) || (hcnt >= G_HI) ||
                  (hcnt >= A_LO && hcnt < A_HI) || (hcnt >= B_LO && hcnt < B_HI);
  assign raw_even = (hcnt >= A_H) && (hcnt < B_H);
  assign cls_even = ~m_ilace | (prohib ? last_even : raw_even);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hri_q     <= '1;
      vri_q     <= '1;
      hcnt      <= '0;
      vhl       <= '0;
      m_direct  <= 1'b0;
      m_hv      <= 1'b1;
      m_ilace   <= 1'b1;
      h_locked  <= 1'b0;
      fld       <= 1'b1;
      last_even <= 1'b1;
      pend      <= 1'b0;
      pend_even <= 1'b1;
      pend_cnt  <= '0;
    end else begin
      hri_q <= {hri_q[1:0], hri_n};
      vri_q <= {vri_q[1:0], vri_n};
      hcnt  <= hcnt_d;
      vhl   <= vhl_d;
      if (h_fall) h_locked <= 1'b1;
      if (enter0) begin
        m_direct <= direct_sel;
        m_hv     <= hv_sel;
        m_ilace  <= interlace_sel;
      end
      if (v_fall) begin
        pend      <= 1'b1;
        pend_cnt  <= '0;
        pend_even <= cls_even;
        if (m_ilace) last_even <= cls_even;
      end else if (pend_hit) begin
        pend <= 1'b0;
      end else if (pend && (line_tick || mid_tick) && pend_cnt != DELAY) begin
        pend_cnt <= pend_cnt + 1'b1;
      end
      if (enter0 || (enter_mid && m_ilace))
        fld <= pend_hit ? pend_even : (m_ilace ? ~fld : 1'b1);
    end
  end

  assign hd_n       = ~(hcnt < HDW_H);
  assign vd_n       = ~((vhl < VDW_V) || (m_ilace && vhl >= V_MID && vhl < V_MEND));
  assign field_even = m_ilace & fld;

  // R2
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) hcnt <= H_LAST);

  // R3
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vhl[0] == (hcnt >= HALF_H));

  // R5
  jitter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fall && h_locked && !h_hard && in_jit && hcnt != H_LAST) |=> (hcnt == $past(hcnt) + 1'b1));

  // R10
  hard_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fall && h_hard) |=> (hcnt == '0));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vhl != '0) |-> $stable({m_direct, m_hv, m_ilace}));

  // R7
  field_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vd_n) && m_ilace && $stable(m_ilace)) |-> (field_even == (hcnt == '0)));

endmodule

// File: tb/test_ext_sync_relock.sv
module test_ext_sync_relock;
  localparam int L = 40, F = 11, HDW = 3, VDH = 5, VD = 6, JIT = 2, OL = 14, EL = 34, G = 1;
  localparam int HALFC = L / 2;
  localparam int FIELD_C = F * L / 2;
  localparam int FRAME_C = F * L;

  logic clk = 0, rst_n = 0, hri_n = 1, vri_n = 1;
  logic direct_sel = 0, hv_sel = 1, interlace_sel = 1;
  logic hd_n, vd_n, field_even;

  ext_sync_relock #(.LINE_CLKS(L), .FRAME_LINES(F), .HD_WIDTH(HDW), .VD_HALVES(VDH),
    .V_DELAY_HALVES(VD), .JITTER_CLKS(JIT), .ODD_LIMIT(OL), .EVEN_LIMIT(EL),
    .GUARD_CLKS(G)) i_ext_sync_relock (
    .clk(clk), .rst_n(rst_n), .hri_n(hri_n), .vri_n(vri_n), .direct_sel(direct_sel),
    .hv_sel(hv_sel), .interlace_sel(interlace_sel), .hd_n(hd_n), .vd_n(vd_n),
    .field_even(field_even));

  always #10 clk = ~clk;

  typedef struct { int at; logic fe; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, total = 0, bad = 0, last_hd = -1, last_vf = -1;
  logic last_vfe = 0, prev_hd = 0, prev_vd = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (prev_hd && !hd_n) last_hd = cyc;
    if (prev_vd && !vd_n) begin
      last_vf = cyc;
      last_vfe = field_even;
      while (q.size() > 0 && q[0].at < cyc) begin
        total++; bad++;
        $display("FAIL %s vd fall missing actual=none expected=cycle %0d", q[0].tag, q[0].at);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].at == cyc) begin
        total++;
        if (field_even !== q[0].fe) begin
          bad++;
          $display("FAIL %s field actual=%0b expected=%0b", q[0].tag, field_even, q[0].fe);
        end
        void'(q.pop_front());
      end
    end
    prev_hd = hd_n;
    prev_vd = vd_n;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string tag, logic ok, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int ph();
    return (cyc - last_hd) % L;
  endfunction

  task automatic wait_ph(int t);
    do step(); while (ph() != t);
  endtask

  task automatic h_try(string tag, int d, logic relock);
    int c0, e;
    wait_ph((d - 3 + L) % L);
    c0 = cyc;
    hri_n = 0;
    repeat (4) step();
    hri_n = 1;
    repeat (L + 8) step();
    e = ((cyc - c0 - 3) + (relock ? 0 : d)) % L;
    chk(tag, ph() == e, ph(), e);
  endtask

  task automatic v_try(string tag, int p, logic ev, int need, output int load);
    int c0, c, h, idx, at;
    wait_ph((p - 2 + L) % L);
    c0 = cyc;
    vri_n = 0;
    c = c0 + 3;
    idx = 0;
    load = -1;
    while (load < 0) begin
      c++;
      h = (c - last_hd) % L;
      if (h == 0 || h == HALFC) begin
        if ((ev ? h == 0 : h == HALFC) && idx >= need) load = c;
        else idx++;
      end
    end
    if (interlace_sel) begin
      at = load + FIELD_C;
      q.push_back('{at, ~ev, tag});
    end else begin
      at = load + FRAME_C;
      q.push_back('{at, 1'b0, tag});
    end
    repeat (2 * L) step();
    vri_n = 1;
    while (cyc <= at + 4) step();
  endtask

  task automatic frame_start();
    int v;
    v = last_vf;
    do step(); while (!(last_vf != v && last_vfe));
  endtask

  initial begin
    int f1, v1, ld;
    repeat (5) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 hd_n", hd_n == 0, hd_n, 0);
    chk("R1 vd_n", vd_n == 0, vd_n, 0);
    chk("R1 field_even", field_even == 1, field_even, 1);

    // R2 line period and width
    while (last_hd < 0) step();
    f1 = last_hd;
    while (last_hd == f1) step();
    chk("R2 period", last_hd - f1 == L, last_hd - f1, L);
    wait_ph(HDW - 1);
    chk("R2 low width", hd_n == 0, hd_n, 0);
    step();
    chk("R2 rise", hd_n == 1, hd_n, 1);

    // R3 free-running fields
    v1 = last_vf;
    while (last_vf == v1) step();
    q.push_back('{last_vf + FIELD_C, ~last_vfe, "R3"});
    q.push_back('{last_vf + FRAME_C, last_vfe, "R3"});
    repeat (FRAME_C + 10) step();

    // R4 first edge relocks even inside jitter window; R5 jitter window
    h_try("R4 first edge", 1, 1);
    h_try("R5 d=2 ignored", 2, 0);
    h_try("R5 d=L-2 ignored", L - 2, 0);
    h_try("R5 d=3 relock", 3, 1);
    h_try("R5 d=L-3 relock", L - 3, 1);

    // R6/R7 continuous style with delay, classification windows
    v_try("R7 odd early", 5, 0, VD, ld);
    v_try("R6 even delayed", 20, 1, VD, ld);
    v_try("R7 odd late", 38, 0, VD, ld);
    // R8 prohibited zone keeps previous (odd)
    v_try("R8 guard", 33, 0, VD, ld);

    // R11 mode change waits for frame start
    frame_start();
    direct_sel = 1; hv_sel = 1;
    h_try("R11 old mode", 2, 0);
    repeat (2 * FRAME_C + 20) step();
    // R10 forcing line-and-frame
    h_try("R10 every edge", 2, 1);

    // R9 forcing frame-only
    hv_sel = 0;
    repeat (2 * FRAME_C + 20) step();
    v_try("R9 even direct", 20, 1, 0, ld);
    v_try("R9 odd direct", 5, 0, 0, ld);

    // R12 non-interlaced
    direct_sel = 0; interlace_sel = 0;
    repeat (2 * FRAME_C + 20) step();
    v_try("R12 align", 5, 1, 0, ld);
    while (cyc < ld + FRAME_C + FIELD_C) step();
    chk("R12 no mid fall", vd_n == 1, vd_n, 1);
    chk("R12 field low", field_even == 0, field_even, 0);

    repeat (10) step();
    while (q.size() > 0) begin
      total++; bad++;
      $display("FAIL %s vd fall missing actual=none expected=cycle %0d", q[0].tag, q[0].at);
      void'(q.pop_front());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule